// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a synchronous binary counter, four bits wide by default, that changes state only on the rising clock edge. A two-bit mode input selects one of four operations: load a new value from the data input, count up, count down, or keep the present value. An active-low count-enable input gates the two counting modes. An active-low terminal-count output is produced from the enable and the present state.

Wider counters are built by feeding each stage's terminal-count output into the enable input of the next stage up. All stages share the same clock and mode inputs. The terminal-count output is a combinational function of the enable input, so a ripple through a chain of stages settles within one clock period. There is no reset pin. The register starts at a value fixed by a parameter.

Top module: `updown_stage`

## Requirements
- R1: Before the first rising clock edge, `q` equals the parameter `INIT`, which defaults to 0.
- R2: With `mode` = 2'b00, `q` takes the value of `din` at the rising edge, whether `cin_n` is low or high.
- R3: With `mode` = 2'b01 and `cin_n` low, `q` increases by one at each rising edge, and the maximum value wraps to 0.
- R4: With `mode` = 2'b10 and `cin_n` low, `q` decreases by one at each rising edge, and 0 wraps to the maximum value.
- R5: With `mode` = 2'b11, `q` keeps its value whatever `cin_n` is.
- R6: With `cin_n` high in mode 2'b01 or 2'b10, `q` keeps its value.
- R7: `cout_n` is low exactly when `cin_n` is low and one of these holds: `mode` = 2'b01 with `q` at its maximum, or `mode` = 2'b10 with `q` = 0. In load and hold modes `cout_n` is high.
- R8: A change on `cin_n` appears on `cout_n` without a clock edge.
- R9: Two stages whose upper `cin_n` is driven by the lower `cout_n` count as one 8-bit counter in both directions, wrapping at 255 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| mode | input | 2 | 00 load, 01 up, 10 down, 11 hold |
| din | input | W | Value taken in load mode |
| cin_n | input | 1 | Active-low count enable / carry in |
| q | output | W | Present count |
| cout_n | output | 1 | Active-low terminal count / carry out |

## Verification
The clocked assertions assume that `mode`, `din` and `cin_n` are stable at each rising edge. They also assume no edge has occurred before the register has taken its initial value. A start flag holds them off until one edge has passed, so `$past` never looks before time zero. The bench changes every input on the falling edge only. It checks `cout_n` between edges, including several `cin_n` toggles within a single half period, which no clocked property can observe.

// File: rtl/updown_stage.sv
module updown_stage #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  input  logic         cin_n,
  output logic [W-1:0] q,
  output logic         cout_n
);
  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DN   = 2'b10;
  localparam logic [1:0] M_HOLD = 2'b11;
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] cnt = INIT;
  logic en;
  logic at_term;

  assign en = !cin_n;

  always_ff @(posedge clk) begin
    case (mode)
      M_LOAD: cnt <= din;
      M_UP:   if (en) cnt <= cnt + 1'b1;
      M_DN:   if (en) cnt <= cnt - 1'b1;
      default: ;
    endcase
  end

  assign at_term = (mode == M_UP && cnt == TOP) || (mode == M_DN && cnt == BOT);
  assign cout_n  = !(en && at_term);
  assign q       = cnt;

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_load_R2: assert property (@(posedge clk) disable iff (!started)
    ($past(mode) == M_LOAD) |-> (q == $past(din)));
  assert_up_R3: assert property (@(posedge clk) disable iff (!started)
    ($past(mode) == M_UP && !$past(cin_n)) |-> (q == $past(q) + 1'b1));
  assert_down_R4: assert property (@(posedge clk) disable iff (!started)
    ($past(mode) == M_DN && !$past(cin_n)) |-> (q == $past(q) - 1'b1));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!started)
    ($past(mode) == M_HOLD) |-> (q == $past(q)));
  assert_gate_R6: assert property (@(posedge clk) disable iff (!started)
    ($past(mode) != M_LOAD && $past(cin_n)) |-> (q == $past(q)));
  assert_cout_R7: assert property (@(posedge clk) disable iff (!started)
    !cout_n |-> (!cin_n && mode != M_LOAD && mode != M_HOLD));
endmodule

// File: tb/tb_updown_stage.sv
module tb_updown_stage;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] mode = 2'b11;
  logic [3:0] din = '0;
  logic cin_n = 1'b1;
  logic [3:0] q;
  logic cout_n;

  logic [1:0] ch_mode = 2'b11;
  logic [7:0] ch_din = '0;
  logic ch_cin = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic lo_cout, hi_cout;

  updown_stage #(.W(4)) dut (.clk(clk), .mode(mode), .din(din), .cin_n(cin_n), .q(q), .cout_n(cout_n));
  updown_stage #(.W(4)) lo  (.clk(clk), .mode(ch_mode), .din(ch_din[3:0]), .cin_n(ch_cin), .q(lo_q), .cout_n(lo_cout));
  updown_stage #(.W(4)) hi  (.clk(clk), .mode(ch_mode), .din(ch_din[7:4]), .cin_n(lo_cout), .q(hi_q), .cout_n(hi_cout));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int model = 0;
  int chm = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_cout(int v, int top, logic [1:0] m, logic c);
    return !(!c && ((m == 2'b01 && v == top) || (m == 2'b10 && v == 0)));
  endfunction

  function automatic int next_val(int v, int mod, logic [1:0] m, logic c, int d);
    if (m == 2'b00) return d;
    if (m == 2'b11 || c) return v;
    if (m == 2'b01) return (v + 1) % mod;
    return (v + mod - 1) % mod;
  endfunction

  function automatic string tag_of(logic [1:0] m, logic c);
    if (m == 2'b00) return "R2";
    if (m == 2'b11) return "R5";
    if (c) return "R6";
    if (m == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic step(logic [1:0] m, int d, logic c);
    int nx;
    @(negedge clk);
    mode = m; din = 4'(d); cin_n = c;
    #1;
    chk(cout_n === exp_cout(model, 15, m, c), "R7", int'(cout_n), int'(exp_cout(model, 15, m, c)));
    nx = next_val(model, 16, m, c, d);
    @(posedge clk);
    #1;
    chk(q === 4'(nx), tag_of(m, c), int'(q), nx);
    model = nx;
  endtask

  task automatic chstep(logic [1:0] m, int d, logic c);
    int nx;
    @(negedge clk);
    ch_mode = m; ch_din = 8'(d); ch_cin = c;
    #1;
    chk(hi_cout === exp_cout(chm, 255, m, c), "R9 carry", int'(hi_cout), int'(exp_cout(chm, 255, m, c)));
    nx = next_val(chm, 256, m, c, d);
    @(posedge clk);
    #1;
    chk({hi_q, lo_q} === 8'(nx), "R9 count", int'({hi_q, lo_q}), nx);
    chm = nx;
  endtask

  initial begin
    #1;
    chk(q === 4'd0, "R1", int'(q), 0);
    for (int v = 0; v < 16; v++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 2; c++) begin
          step(2'b00, v, 1'(v + c));
          step(2'(m), (v * 7 + 3) % 16, 1'(c));
        end
    step(2'b00, 13, 1'b0);
    for (int i = 0; i < 20; i++) step(2'b01, 0, 1'(i % 5 == 4));
    for (int i = 0; i < 20; i++) step(2'b10, 9, 1'(i % 6 == 5));
    step(2'b00, 15, 1'b1);
    @(negedge clk);
    mode = 2'b01; cin_n = 1'b1; #1;
    chk(cout_n === 1'b1, "R8", int'(cout_n), 1);
    cin_n = 1'b0; #1;
    chk(cout_n === 1'b0, "R8", int'(cout_n), 0);
    cin_n = 1'b1; #1;
    chk(cout_n === 1'b1, "R8", int'(cout_n), 1);
    mode = 2'b11; cin_n = 1'b0; #1;
    chk(cout_n === 1'b1, "R7", int'(cout_n), 1);
    chstep(2'b00, 8'hFB, 1'b0);
    for (int i = 0; i < 24; i++) chstep(2'b01, 0, 1'(i == 10));
    chstep(2'b00, 8'h12, 1'b0);
    for (int i = 0; i < 24; i++) chstep(2'b10, 0, 1'(i == 7));
    chstep(2'b11, 0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule